// File: doc/BRIEF.md
# Audio Receive Word FIFO with Sticky Status

This block sits between the word assembler of an audio serial receiver and the register file that software reads. The receiver hands it complete sample words with a one-cycle push strobe. Software takes the words out with a pop strobe. The oldest stored word is always visible on the read data output, so a pop consumes the word shown in that same cycle. There are eight storage slots.

The block reports how many words it holds and whether the FIFO is full. It also raises a threshold flag once the fill reaches a value that software programs. Two sticky error flags record a push into a full FIFO and a pop from an empty one. Each error flag stays set until its own clear strobe is pulsed. A push into a full FIFO is not lost: the new word takes the slot of the oldest one. The receive interrupt request combines the threshold flag and the overflow flag, and an enable input gates it.

Top module: `rx_audio_fifo`

## Requirements
- R1: Words leave in the order they arrived. While the FIFO holds at least one word, `pop_data_o` shows the oldest word in the same cycle. A pop at a rising edge removes that word.
- R2: `level_o` is a registered count from 0 to 8 that changes at the rising edge where a push or pop is sampled. A push adds one and a pop of a non-empty FIFO removes one. A push and a pop together leave the count unchanged, unless the FIFO was empty.
- R3: `full_o` is 1 exactly when `level_o` equals 8.
- R4: `thresh_o` is 1 whenever `level_o` is greater than or equal to the unsigned value on `thresh_i`, and 0 otherwise. A threshold of 0 therefore keeps it at 1.
- R5: A push sampled while the FIFO is full and no pop is sampled sets `ovf_o` at that edge. The new word replaces the oldest stored word and `level_o` stays at 8. A push together with a pop on a full FIFO is not an overflow.
- R6: A pop sampled while the FIFO is empty sets `udf_o` at that edge. It leaves `level_o` unchanged, and `pop_data_o` reads all zeros while the FIFO is empty.
- R7: `ovf_o` and `udf_o` stay at 1 until a 1 is sampled on their own clear strobe (`ovf_clr_i`, `udf_clr_i`). A clear strobe held at 0 has no effect.
- R8: When a set event and the matching clear strobe are sampled at the same edge, the flag is 1 after that edge.
- R9: `irq_o` is 1 exactly when `irq_en_i` is 1 and either `thresh_o` or `ovf_o` is 1.
- R10: A 0 on `rst_n` sampled at a rising edge empties the FIFO and clears `ovf_o` and `udf_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Write strobe from the receiver |
| push_data_i | input | 32 | Word to store |
| pop_i | input | 1 | Read strobe from software |
| pop_data_o | output | 32 | Oldest stored word, or zero when empty |
| thresh_i | input | 3 | Programmable fill threshold |
| ovf_clr_i | input | 1 | Write-1 strobe that clears the overflow flag |
| udf_clr_i | input | 1 | Write-1 strobe that clears the underflow flag |
| irq_en_i | input | 1 | Receive interrupt enable |
| level_o | output | 4 | Number of stored words |
| full_o | output | 1 | FIFO holds eight words |
| thresh_o | output | 1 | Fill level at or above the threshold |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The count and both sticky flags are registered. They take their new value at the rising edge that samples a strobe. `pop_data_o`, `full_o`, `thresh_o` and `irq_o` follow from that registered state and the current inputs within the same cycle. The bench drives all inputs on the falling edge and samples every output 2 ns later, before the next rising edge. At that point it compares the outputs against a queue model that advances only at the rising edge. Every result is therefore compared in the first cycle where it is due.

// File: rtl/rxq_pkg.sv
// Package: shared types for the receive word FIFO.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package rxq_pkg;

    // Error events detected by the storage and handed to the sticky flags.
    typedef struct packed {
        logic ovf;   // push into a full FIFO without a matching pop
        logic udf;   // pop from an empty FIFO
    } rxq_evt_t;

endpackage

// File: rtl/rxq_store.sv
// Module: rxq_store
// Circular word storage with read/write pointers and an explicit word count.
// A push into a full FIFO (with no pop) overwrites the oldest slot and moves
// the read pointer along, so the count stays at DEPTH. A pop of an empty FIFO
// changes nothing and is reported as an underflow event.
// Assumes: synchronous active-low reset; DEPTH >= 2.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] pop_data_o,
    output logic [CW-1:0]     count_o,
    output rxq_evt_t          evt_o
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]     count_q;
    logic              is_full, is_empty, pop_ok, overwrite, rd_adv;

    // Wrap a pointer at DEPTH, so DEPTH need not be a power of two.
    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + AW'(1);
    endfunction

    // Decode the strobes against the current fill state.
    always_comb begin
        is_full   = (count_q == FULL_CNT);
        is_empty  = (count_q == '0);
        pop_ok    = pop_i & ~is_empty;
        overwrite = push_i & is_full & ~pop_i;
        rd_adv    = pop_ok | overwrite;
    end

    // One register per slot; written only when the write pointer selects it.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_i && wr_ptr_q == AW'(gi))
                slot_q[gi] <= push_data_i;
        end
    end

    // Advance the pointers and keep the word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
            if (rd_adv) rd_ptr_q <= ptr_inc(rd_ptr_q);
            unique case ({push_i, pop_ok})
                2'b10:   count_q <= is_full ? count_q : count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // Present the oldest word, or zero when nothing is stored.
    always_comb begin
        pop_data_o = is_empty ? '0 : slot_q[rd_ptr_q];
        count_o    = count_q;
        evt_o.ovf  = overwrite;
        evt_o.udf  = pop_i & is_empty;
    end

    // R2
    level_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_CNT);

    // R2
    level_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && count_q != FULL_CNT) |=> count_q == $past(count_q) + CW'(1));

    // R5
    ovw_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && count_q == FULL_CNT) |=> count_q == FULL_CNT);

    // R6
    udf_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && count_q == '0) |=> $stable(count_q));

endmodule

// File: rtl/rxq_sticky.sv
// Module: rxq_sticky
// One sticky status bit. It is set by an event and cleared by a write-1 strobe,
// and a set in the same cycle as a clear wins.
// Assumes: synchronous active-low reset; set and clear are single-cycle levels.
module rxq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Hold the flag; a set overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R7
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/rxq_status.sv
// Module: rxq_status
// Combinational status derived from the stored count: the full flag, the
// threshold flag and the gated receive interrupt request.
// Assumes: THR_W <= CW so the threshold fits the count width.
module rxq_status #(
    parameter int DEPTH = 8,
    parameter int THR_W = 3,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0]    count_i,
    input  logic [THR_W-1:0] thresh_i,
    input  logic             irq_en_i,
    input  logic             ovf_i,
    output logic             full_o,
    output logic             thresh_o,
    output logic             irq_o
);

    logic [CW-1:0] thr_ext;

    // Compare the fill against the threshold and form the interrupt request.
    always_comb begin
        thr_ext  = CW'(thresh_i);
        full_o   = (count_i == CW'(DEPTH));
        thresh_o = (count_i >= thr_ext);
        irq_o    = irq_en_i & (thresh_o | ovf_i);
    end

endmodule

// File: rtl/rx_audio_fifo.sv
// Module: rx_audio_fifo (top)
// Eight-word receive FIFO for an audio serial receiver, with a fill level,
// threshold, full, sticky overflow/underflow and an interrupt request.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module rx_audio_fifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int THR_W  = 3,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] pop_data_o,
    input  logic [THR_W-1:0]  thresh_i,
    input  logic              ovf_clr_i,
    input  logic              udf_clr_i,
    input  logic              irq_en_i,
    output logic [CW-1:0]     level_o,
    output logic              full_o,
    output logic              thresh_o,
    output logic              ovf_o,
    output logic              udf_o,
    output logic              irq_o
);

    rxq_evt_t evt;

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .push_data_i (push_data_i),
        .pop_i       (pop_i),
        .pop_data_o  (pop_data_o),
        .count_o     (level_o),
        .evt_o       (evt)
    );

    rxq_sticky u_ovf (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt.ovf),
        .clr_i  (ovf_clr_i),
        .flag_o (ovf_o)
    );

    rxq_sticky u_udf (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt.udf),
        .clr_i  (udf_clr_i),
        .flag_o (udf_o)
    );

    rxq_status #(.DEPTH(DEPTH), .THR_W(THR_W)) u_status (
        .count_i  (level_o),
        .thresh_i (thresh_i),
        .irq_en_i (irq_en_i),
        .ovf_i    (ovf_o),
        .full_o   (full_o),
        .thresh_o (thresh_o),
        .irq_o    (irq_o)
    );

    // R3
    full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> level_o == CW'(DEPTH));

    // R6
    empty_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == '0) |-> pop_data_o == '0);

endmodule

// File: tb/rx_audio_fifo_bench.sv
`timescale 1ns/1ps
module rx_audio_fifo_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 1'b0, pop = 1'b0, oclr = 1'b0, uclr = 1'b0, ien = 1'b0;
    logic [31:0] pdata = '0;
    logic [2:0]  th = 3'd1;
    logic [31:0] rdata;
    logic [3:0]  level;
    logic        full, thr, ovf, udf, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] mq[$];
    bit m_ovf = 0, m_udf = 0;
    logic [31:0] seq = 32'h100;

    always #10 clk = ~clk;

    rx_audio_fifo u_rx_audio_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(pdata), .pop_i(pop),
        .pop_data_o(rdata), .thresh_i(th), .ovf_clr_i(oclr), .udf_clr_i(uclr),
        .irq_en_i(ien), .level_o(level), .full_o(full), .thresh_o(thr),
        .ovf_o(ovf), .udf_o(udf), .irq_o(irq)
    );

    function automatic bit e_thr(int sz, int t);
        return sz >= t;
    endfunction

    function automatic bit e_irq(bit en, int sz, int t, bit of);
        return en && (e_thr(sz, t) || of);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare every output against the model state (before the next rising edge).
    task automatic check_all();
        int sz = mq.size();
        chk("R2 level", 32'(level), 32'(sz));
        chk("R3 full", 32'(full), 32'(sz == 8));
        chk("R4 threshold", 32'(thr), 32'(e_thr(sz, int'(th))));
        chk("R1/R6 read data", rdata, (sz > 0) ? mq[0] : 32'h0);
        chk("R5/R7/R8 overflow flag", 32'(ovf), 32'(m_ovf));
        chk("R6/R7/R8 underflow flag", 32'(udf), 32'(m_udf));
        chk("R9 irq", 32'(irq), 32'(e_irq(ien, sz, int'(th), m_ovf)));
    endtask

    // One cycle: drive on the falling edge, check, then advance the model at the rising edge.
    task automatic step(input bit p, input bit r, input bit co, input bit cu);
        int sz;
        bit so, su;
        logic [31:0] d;
        @(negedge clk);
        seq  = seq + 32'h1;
        d    = {seq[15:0], ~seq[15:0]};
        push = p; pdata = d; pop = r; oclr = co; uclr = cu;
        #2;
        check_all();
        @(posedge clk);
        sz = mq.size(); so = 0; su = 0;
        if (r && sz == 0) su = 1;
        if (r && sz > 0) void'(mq.pop_front());
        if (p) begin
            if (sz == 8 && !r) begin
                so = 1;
                void'(mq.pop_front());
            end
            mq.push_back(d);
        end
        m_ovf = so ? 1'b1 : (co ? 1'b0 : m_ovf);
        m_udf = su ? 1'b1 : (cu ? 1'b0 : m_udf);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push = 0; pop = 0; oclr = 0; uclr = 0;
        repeat (3) @(posedge clk);
        mq.delete(); m_ovf = 0; m_udf = 0;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R10: reset leaves the FIFO empty with both flags clear
        chk("R10 level after reset", 32'(level), 32'h0);
        chk("R10 ovf after reset", 32'(ovf), 32'h0);
        chk("R10 udf after reset", 32'(udf), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        ien = 1'b1;
        // R4: threshold compare around three words
        th = 3'd3;
        repeat (3) step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        th = 3'd4;
        step(0, 0, 0, 0);
        // R3/R5: fill, then overflow twice (oldest words replaced)
        repeat (5) step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        // R5: push with pop on a full FIFO is not an overflow; clear first
        step(0, 0, 1, 0);
        step(1, 1, 0, 0);
        // R8: overflow and clear together -> flag stays set
        step(1, 0, 1, 0);
        // R7: clear strobe held low leaves the flag
        repeat (2) step(0, 0, 0, 0);
        step(0, 0, 1, 0);
        // R1: drain in order
        repeat (8) step(0, 1, 0, 0);
        // R6: pop empty sets underflow, data reads zero
        step(0, 1, 0, 0);
        step(0, 0, 0, 0);
        step(0, 1, 0, 1);   // R8 on underflow
        step(0, 0, 1, 1);   // R7 clear
        step(1, 1, 0, 0);   // push and pop on empty
        // R4/R9: threshold zero and interrupt disabled
        th = 3'd0;
        step(0, 0, 0, 0);
        ien = 1'b0;
        step(0, 0, 0, 0);
        // R10: reset in the middle of activity
        repeat (5) step(1, 0, 0, 0);
        do_reset();
        // Constrained random phases: fill-heavy, drain-heavy, balanced
        for (int ph = 0; ph < 3; ph++) begin
            for (int k = 0; k < 600; k++) begin
                int pr = (ph == 0) ? 75 : (ph == 1) ? 25 : 50;
                bit p = ($urandom % 100) < pr;
                bit r = ($urandom % 100) < (100 - pr);
                bit co = ($urandom % 10) == 0;
                bit cu = ($urandom % 10) == 0;
                if (($urandom % 16) == 0) th = 3'($urandom);
                if (($urandom % 32) == 0) ien = ~ien;
                step(p, r, co, cu);
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule